// File: doc/BRIEF.md
# Wiper Position Counter Register

This block keeps the 8-bit volatile position of a digital potentiometer wiper. Its output is a 256-line tap-select bus with exactly one line high. Code 00h selects the low-end tap and code FFh selects the high-end tap. The surrounding bus controller updates the position in four ways:

- a recall pulse, raised once at power-up, carries the stored default value;
- a parallel load carries the contents of a selected data register;
- a serial load carries a byte written directly by the host;
- a step session is held open by the controller from the acknowledge of the increment/decrement command until the stop condition.

While a step session is open, every rising edge of the bus clock line moves the wiper one tap. The level of the bus data line at that edge picks the direction: high steps toward the high end and low steps toward the low end. Steps saturate at both ends.

The current position is also output in binary, for read-back and for saving into a data register. Each load port is a single-cycle valid strobe with its data. No load is ever back-pressured: a strobe is consumed in the cycle it is seen, so the block has no ready outputs. When several sources act in the same cycle, a fixed priority picks one and the others are dropped. The tap-select bus is registered, so it follows the position one clock later.

Top module: `wiper_pos_ctrl`

## Requirements
- R1: After reset the position output reads 00h and only tap-select bit 0 is high.
- R2: Exactly one tap-select bit is high in every cycle. Bit n corresponds to position code n, so bit 0 is the low end and bit 255 is the high end.
- R3: The tap-select bus is registered. After each clock edge it shows the position that held before that edge.
- R4: A recall strobe loads its data into the position on the next edge, whatever the other sources do in that cycle.
- R5: When there is no recall, a parallel-load strobe loads its data and wins over serial loads and steps in the same cycle.
- R6: When there is no recall or parallel load, a serial-load strobe replaces the position on the next edge and wins over a step in the same cycle.
- R7: While the session input is high and no load is active, a rising edge on the bus clock input with the bus data input high adds one to the position.
- R8: Under the same conditions with the bus data input low, one is subtracted from the position.
- R9: A step up at FFh leaves FFh, and a step down at 00h leaves 00h.
- R10: With no load and no qualifying step, the position holds. This covers the session input low, and the bus clock input staying high or low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| recall_vld | input | 1 | Power-up recall strobe |
| recall_val | input | 8 | Default position to recall |
| par_vld | input | 1 | Parallel load strobe |
| par_val | input | 8 | Data register contents to load |
| ser_vld | input | 1 | Serial (direct) load strobe |
| ser_val | input | 8 | Host-written position |
| step_session | input | 1 | High while a step session is open |
| bus_scl | input | 1 | Synchronised bus clock level |
| bus_sda | input | 1 | Synchronised bus data level |
| pos_q | output | 8 | Current wiper position |
| tap_sel | output | 256 | One-hot tap select, registered |

## Verification
The bench builds the block with its default 8-bit position, which gives the full 256-line tap bus. It uses fixed serial loads of FEh and 01h so that saturation at either end is one or two steps away. It does not walk 255 steps to reach an end. Random cycles mix all four sources, often several at once. The session input and both bus lines are toggled freely, so priority clashes, held clock levels and closed sessions all come up many times.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
  typedef enum logic [2:0] {
    SRC_HOLD   = 3'd0,
    SRC_RECALL = 3'd1,
    SRC_PAR    = 3'd2,
    SRC_SER    = 3'd3,
    SRC_UP     = 3'd4,
    SRC_DOWN   = 3'd5
  } wiper_src_e;
endpackage

// File: rtl/wiper_step_detect.sv
module wiper_step_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic session,
  input  logic scl,
  input  logic sda,
  output logic step_req,
  output logic step_up
);
  logic scl_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) scl_d <= 1'b0;
    else        scl_d <= scl;
  end

  assign step_req = session & scl & ~scl_d;
  assign step_up  = sda;
endmodule

// File: rtl/wiper_src_arbiter.sv
module wiper_src_arbiter
  import wiper_pkg::*;
#(
  parameter int POS_W = 8
) (
  input  logic             recall_vld,
  input  logic [POS_W-1:0] recall_val,
  input  logic             par_vld,
  input  logic [POS_W-1:0] par_val,
  input  logic             ser_vld,
  input  logic [POS_W-1:0] ser_val,
  input  logic             step_req,
  input  logic             step_up,
  output wiper_src_e       src,
  output logic [POS_W-1:0] load_val
);
  always_comb begin
    src      = SRC_HOLD;
    load_val = '0;
    if (recall_vld) begin
      src      = SRC_RECALL;
      load_val = recall_val;
    end else if (par_vld) begin
      src      = SRC_PAR;
      load_val = par_val;
    end else if (ser_vld) begin
      src      = SRC_SER;
      load_val = ser_val;
    end else if (step_req) begin
      src = step_up ? SRC_UP : SRC_DOWN;
    end
  end
endmodule

// File: rtl/wiper_pos_reg.sv
module wiper_pos_reg
  import wiper_pkg::*;
#(
  parameter int POS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  wiper_src_e       src,
  input  logic [POS_W-1:0] load_val,
  output logic [POS_W-1:0] pos
);
  localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};
  localparam logic [POS_W-1:0] POS_MIN = '0;

  logic [POS_W-1:0] pos_nxt;

  always_comb begin
    pos_nxt = pos;
    unique case (src)
      SRC_RECALL, SRC_PAR, SRC_SER: pos_nxt = load_val;
      SRC_UP:   if (pos != POS_MAX) pos_nxt = pos + 1'b1;
      SRC_DOWN: if (pos != POS_MIN) pos_nxt = pos - 1'b1;
      default:  pos_nxt = pos;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos <= POS_MIN;
    else        pos <= pos_nxt;
  end
endmodule

// File: rtl/wiper_tap_decode.sv
module wiper_tap_decode #(
  parameter int POS_W = 8,
  localparam int TAPS = 1 << POS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [POS_W-1:0] pos,
  output logic [TAPS-1:0]  tap
);
  for (genvar gi = 0; gi < TAPS; gi++) begin : g_tap
    localparam logic TAP_RST = (gi == 0);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tap[gi] <= TAP_RST;
      else        tap[gi] <= (pos == POS_W'(gi));
    end
  end
endmodule

// File: rtl/wiper_pos_ctrl.sv
module wiper_pos_ctrl
  import wiper_pkg::*;
#(
  parameter int POS_W = 8,
  localparam int TAPS = 1 << POS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             recall_vld,
  input  logic [POS_W-1:0] recall_val,
  input  logic             par_vld,
  input  logic [POS_W-1:0] par_val,
  input  logic             ser_vld,
  input  logic [POS_W-1:0] ser_val,
  input  logic             step_session,
  input  logic             bus_scl,
  input  logic             bus_sda,
  output logic [POS_W-1:0] pos_q,
  output logic [TAPS-1:0]  tap_sel
);
  logic             step_req;
  logic             step_up;
  wiper_src_e       src;
  logic [POS_W-1:0] load_val;

  wiper_step_detect u_step (
    .clk      (clk),
    .rst_n    (rst_n),
    .session  (step_session),
    .scl      (bus_scl),
    .sda      (bus_sda),
    .step_req (step_req),
    .step_up  (step_up)
  );

  wiper_src_arbiter #(.POS_W(POS_W)) u_arb (
    .recall_vld (recall_vld),
    .recall_val (recall_val),
    .par_vld    (par_vld),
    .par_val    (par_val),
    .ser_vld    (ser_vld),
    .ser_val    (ser_val),
    .step_req   (step_req),
    .step_up    (step_up),
    .src        (src),
    .load_val   (load_val)
  );

  wiper_pos_reg #(.POS_W(POS_W)) u_pos (
    .clk      (clk),
    .rst_n    (rst_n),
    .src      (src),
    .load_val (load_val),
    .pos      (pos_q)
  );

  wiper_tap_decode #(.POS_W(POS_W)) u_dec (
    .clk   (clk),
    .rst_n (rst_n),
    .pos   (pos_q),
    .tap   (tap_sel)
  );
endmodule

// File: rtl/wiper_pos_ctrl_chk.sv
module wiper_pos_ctrl_chk #(
  parameter int POS_W = 8,
  localparam int TAPS = 1 << POS_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             recall_vld,
  input logic [POS_W-1:0] recall_val,
  input logic             par_vld,
  input logic [POS_W-1:0] par_val,
  input logic             ser_vld,
  input logic [POS_W-1:0] ser_val,
  input logic             step_session,
  input logic             bus_sda,
  input logic [POS_W-1:0] pos_q,
  input logic [TAPS-1:0]  tap_sel
);
  localparam logic [POS_W-1:0] PMAX = {POS_W{1'b1}};
  logic any_load;
  assign any_load = recall_vld | par_vld | ser_vld;

  // R2
  tap_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tap_sel) == 1);

  // R3
  tap_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> tap_sel == (TAPS'(1) << $past(pos_q)));

  // R4
  recall_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recall_vld |=> pos_q == $past(recall_val));

  // R5
  par_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (par_vld && !recall_vld) |=> pos_q == $past(par_val));

  // R6
  ser_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_vld && !par_vld && !recall_vld) |=> pos_q == $past(ser_val));

  // R9
  sat_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_load && step_session && bus_sda && pos_q == PMAX) |=> pos_q == PMAX);

  // R9
  sat_bot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_load && step_session && !bus_sda && pos_q == '0) |=> pos_q == '0);

  // R10
  closed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_load && !step_session) |=> $stable(pos_q));
endmodule

bind wiper_pos_ctrl wiper_pos_ctrl_chk #(.POS_W(POS_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .recall_vld   (recall_vld),
  .recall_val   (recall_val),
  .par_vld      (par_vld),
  .par_val      (par_val),
  .ser_vld      (ser_vld),
  .ser_val      (ser_val),
  .step_session (step_session),
  .bus_sda      (bus_sda),
  .pos_q        (pos_q),
  .tap_sel      (tap_sel)
);

// File: tb/wiper_pos_ctrl_tb.sv
module wiper_pos_ctrl_tb;
  localparam int POS_W = 8;
  localparam int TAPS  = 1 << POS_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             recall_vld = 1'b0, par_vld = 1'b0, ser_vld = 1'b0;
  logic [POS_W-1:0] recall_val = '0, par_val = '0, ser_val = '0;
  logic             step_session = 1'b0, bus_scl = 1'b0, bus_sda = 1'b0;
  logic [POS_W-1:0] pos_q;
  logic [TAPS-1:0]  tap_sel;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  logic [POS_W-1:0] m_pos = '0;
  bit               m_scl = 1'b0;

  always #2 clk = ~clk;

  wiper_pos_ctrl #(.POS_W(POS_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .recall_vld(recall_vld), .recall_val(recall_val),
    .par_vld(par_vld), .par_val(par_val),
    .ser_vld(ser_vld), .ser_val(ser_val),
    .step_session(step_session), .bus_scl(bus_scl), .bus_sda(bus_sda),
    .pos_q(pos_q), .tap_sel(tap_sel)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [TAPS-1:0] act, input logic [TAPS-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [TAPS-1:0] onehot_of(input logic [POS_W-1:0] p);
    return TAPS'(1) << p;
  endfunction

  task automatic cyc(input bit rv, input logic [POS_W-1:0] rd,
                     input bit pv, input logic [POS_W-1:0] pd,
                     input bit sv, input logic [POS_W-1:0] sd,
                     input bit so, input bit s_scl, input bit s_sda);
    logic [POS_W-1:0] prev;
    string tag;
    bit rise;
    @(negedge clk);
    recall_vld = rv; recall_val = rd; par_vld = pv; par_val = pd;
    ser_vld = sv; ser_val = sd; step_session = so; bus_scl = s_scl; bus_sda = s_sda;
    @(posedge clk);
    prev = m_pos;
    rise = s_scl && !m_scl;
    if (rv) begin m_pos = rd; tag = "R4"; end
    else if (pv) begin m_pos = pd; tag = "R5"; end
    else if (sv) begin m_pos = sd; tag = "R6"; end
    else if (so && rise) begin
      if (s_sda) begin
        if (m_pos == '1) tag = "R9"; else begin m_pos = m_pos + 1'b1; tag = "R7"; end
      end else begin
        if (m_pos == '0) tag = "R9"; else begin m_pos = m_pos - 1'b1; tag = "R8"; end
      end
    end else tag = "R10";
    m_scl = s_scl;
    #1;
    chk(pos_q == m_pos, tag, TAPS'(pos_q), TAPS'(m_pos));
    chk(tap_sel == onehot_of(prev), "R3", tap_sel, onehot_of(prev));
    chk($countones(tap_sel) == 1, "R2", tap_sel, onehot_of(prev));
  endtask

  task automatic idle(); cyc(0, 0, 0, 0, 0, 0, 0, 0, 0); endtask
  task automatic sload(input logic [POS_W-1:0] v); cyc(0, 0, 0, 0, 1, v, 0, 0, 0); endtask
  task automatic pulse(input bit dir);
    cyc(0, 0, 0, 0, 0, 0, 1, 1, dir);
    cyc(0, 0, 0, 0, 0, 0, 1, 0, dir);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(pos_q == '0, "R1", TAPS'(pos_q), '0);
    chk(tap_sel == onehot_of('0), "R1", tap_sel, onehot_of('0));
    @(negedge clk); rst_n = 1'b1;

    // R4 recall then R6 serial replace
    cyc(1, 8'h5A, 0, 0, 0, 0, 0, 0, 0);
    sload(8'hC3);
    idle();
    // R4/R5/R6 priority clash
    cyc(1, 8'h11, 1, 8'h22, 1, 8'h33, 1, 1, 1);
    cyc(0, 0, 1, 8'h44, 1, 8'h55, 1, 0, 0);
    cyc(0, 0, 0, 0, 1, 8'h66, 1, 1, 1);
    idle();
    // R7, R9 at the top
    sload(8'hFE);
    pulse(1); pulse(1); pulse(1);
    // R8, R9 at the bottom
    sload(8'h01);
    pulse(0); pulse(0); pulse(0);
    // R10 clock held high, then session closed
    sload(8'h80);
    cyc(0, 0, 0, 0, 0, 0, 1, 1, 1);
    cyc(0, 0, 0, 0, 0, 0, 1, 1, 1);
    cyc(0, 0, 0, 0, 0, 0, 1, 1, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 1);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      bit rv, pv, sv, so, c, d;
      rv = ($urandom_range(0, 31) == 0);
      pv = ($urandom_range(0, 15) == 0);
      sv = ($urandom_range(0, 11) == 0);
      so = ($urandom_range(0, 3) != 0);
      c  = $urandom_range(0, 1);
      d  = ($urandom_range(0, 9) < (i[9] ? 7 : 3));
      cyc(rv, 8'($urandom), pv, 8'($urandom), sv, 8'($urandom), so, c, d);
    end

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule